// File: doc/BRIEF.md
# Split-Word Strobed RAM Port

This block gives a host that only has plain read and write strobes access to a 1024-entry, 24-bit memory. The host sets a 10-bit address and a word-select bit. It then pulls an active-low read or write strobe. The shared 24-bit data path is split into an input side and an output side with an enable. Together these model a tri-state bus. The output side is treated as high impedance whenever its enable is low.

The access width comes from a 3-bit mode code. In full mode, every access moves a whole 24-bit word. In split mode, each word is seen as two parts: a 16-bit lower part and an 8-bit upper part. The word-select bit picks the part, and the selected part always travels on the low bus lanes. Both strobes are asynchronous to the block clock. They pass through a two-flop synchronizer, and the block acts on the edges it detects there. A strobe edge therefore takes effect a few clock cycles after it happens at the pins.

Top module: `split_ram_port`

## Requirements
- R1: Mode code 3'b110 selects full access and 3'b111 selects split access. With any other code, strobes are ignored: a write leaves memory unchanged and a read leaves busOe low.
- R2: Address and upperSel are captured when a falling strobe edge is detected. This happens no more than 3 clock cycles after the pin falls. Later changes to them have no effect on that access.
- R3: Write data is taken from busIn when the rising edge of wrN is detected. busIn must stay stable for 3 clock cycles after wrN rises. Earlier values on busIn are not stored.
- R4: In full mode, reads and writes move all 24 bits (bus bit i maps to word bit i), and upperSel has no effect.
- R5: In split mode with upperSel low, bus bits 15..0 map to word bits 15..0. A read drives zeros on bus bits 23..16. A write leaves word bits 23..16 unchanged.
- R6: In split mode with upperSel high, bus bits 7..0 map to word bits 23..16. A read drives zeros on bus bits 23..8. A write leaves word bits 15..0 unchanged.
- R7: busOe is high only during a captured read cycle while the synchronized rdN is low. It falls within 3 clock cycles after rdN rises. busOut reads zero whenever busOe is low.
- R8: After reset, busOe is low and busOut is zero.
- R9: If both strobes are seen low together, any access in progress is abandoned. No memory write takes place and busOe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for strobe synchronization and all state |
| rstN | input | 1 | Asynchronous active-low reset |
| modeCode | input | 3 | Access mode: 110 full, 111 split, others disable access |
| addrIn | input | 10 | Word address, captured on the strobe falling edge |
| upperSel | input | 1 | In split mode, selects the upper 8-bit part (1) or the lower 16-bit part (0) |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| busIn | input | 24 | Bus data arriving from the host |
| busOut | output | 24 | Bus data driven to the host |
| busOe | output | 1 | Bus drive enable; when low, the bus is high impedance |

## Verification
On every cycle, the assertions check the following:
- Capture events occur only under a valid mode code.
- Capture events never occur when both strobes were low.
- A memory commit always follows a high wrN sample.
- busOe always matches a low read strobe seen through the synchronizer.
- Split reads of the upper part drive zero on the top lanes.

Only the bench scenarios can show that data lands in the right bits of the right word. They cover part merging in split writes, the ignoring of upperSel in full mode, address and data hold after capture, and the unchanged contents after invalid-mode and double-strobe accesses. A reference memory in the bench tracks all of this.

// File: rtl/split_ram_pkg.sv
package split_ram_pkg;
  typedef struct packed {
    logic latchRd;   // read cycle captured this clock
    logic latchWr;   // write cycle captured this clock
    logic commitWr;  // store bus data into memory this clock
    logic driveOut;  // bus drive enable
  } ctrlStrobes_t;
endpackage

// File: rtl/split_ram_ctrl.sv
module split_ram_ctrl
  import split_ram_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeOk,
  input  logic         rdN,
  input  logic         wrN,
  output ctrlStrobes_t strobes
);
  localparam int NUM_STROBES = 2;

  logic [NUM_STROBES-1:0] rawStrobe;
  logic [NUM_STROBES-1:0] syncStrobe;
  logic [NUM_STROBES-1:0] prevStrobe;

  assign rawStrobe = {wrN, rdN};

  genvar g;
  generate
    for (g = 0; g < NUM_STROBES; g++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[SYNC_STAGES-2:0], rawStrobe[g]};
      end
      assign syncStrobe[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevStrobe <= '1;
    else       prevStrobe <= syncStrobe;
  end

  logic rdS, wrS, rdFall, wrFall, rdRise, wrRise, bothLow;
  assign rdS     = syncStrobe[0];
  assign wrS     = syncStrobe[1];
  assign rdFall  = prevStrobe[0] & ~rdS;
  assign wrFall  = prevStrobe[1] & ~wrS;
  assign rdRise  = ~prevStrobe[0] & rdS;
  assign wrRise  = ~prevStrobe[1] & wrS;
  assign bothLow = ~rdS & ~wrS;

  logic cycActive, cycWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycActive <= 1'b0;
      cycWrite  <= 1'b0;
    end else if (bothLow) begin
      cycActive <= 1'b0;
    end else if (strobes.latchRd || strobes.latchWr) begin
      cycActive <= 1'b1;
      cycWrite  <= strobes.latchWr;
    end else if (cycActive && ((cycWrite && wrRise) || (!cycWrite && rdRise))) begin
      cycActive <= 1'b0;
    end
  end

  always_comb begin
    strobes.latchRd  = modeOk & rdFall & wrS;
    strobes.latchWr  = modeOk & wrFall & rdS;
    strobes.commitWr = cycActive & cycWrite & wrRise & rdS;
    strobes.driveOut = cycActive & ~cycWrite & ~rdS & wrS;
  end
endmodule

// File: rtl/split_ram_datapath.sv
module split_ram_datapath
  import split_ram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              splitSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              upperSel,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              latSplit,
  output logic              latUpper
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = DATA_W - LO_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] latAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr  <= '0;
      latSplit <= 1'b0;
      latUpper <= 1'b0;
    end else if (strobes.latchRd || strobes.latchWr) begin
      latAddr  <= addrIn;
      latSplit <= splitSel;
      latUpper <= upperSel;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commitWr) begin
      if (!latSplit)     memArr[latAddr]                <= busIn;
      else if (latUpper) memArr[latAddr][DATA_W-1:LO_W] <= busIn[HI_W-1:0];
      else               memArr[latAddr][LO_W-1:0]      <= busIn[LO_W-1:0];
    end
  end

  logic [DATA_W-1:0] rdWord, fmtWord;
  assign rdWord = memArr[latAddr];

  always_comb begin
    fmtWord = '0;
    if (!latSplit)     fmtWord               = rdWord;
    else if (latUpper) fmtWord[HI_W-1:0]     = rdWord[DATA_W-1:LO_W];
    else               fmtWord[LO_W-1:0]     = rdWord[LO_W-1:0];
  end

  assign busOut = strobes.driveOut ? fmtWord : '0;
endmodule

// File: rtl/split_ram_port.sv
module split_ram_port
  import split_ram_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 24,
  parameter int LO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeCode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              upperSel,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);
  ctrlStrobes_t strobes;
  logic modeOk, latSplit, latUpper;

  assign modeOk = (modeCode[2:1] == 2'b11);

  split_ram_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .modeOk(modeOk), .rdN(rdN), .wrN(wrN), .strobes(strobes)
  );

  split_ram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .splitSel(modeCode[0]),
    .addrIn(addrIn), .upperSel(upperSel), .busIn(busIn), .busOut(busOut),
    .latSplit(latSplit), .latUpper(latUpper)
  );

  assign busOe = strobes.driveOut;
endmodule

// File: rtl/split_ram_port_chk.sv
module split_ram_port_chk
  import split_ram_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        modeCode,
  input logic              rdN,
  input logic              wrN,
  input logic [DATA_W-1:0] busOut,
  input logic              busOe,
  input ctrlStrobes_t      strobes,
  input logic              latSplit,
  input logic              latUpper
);
  localparam int HI_W = DATA_W - LO_W;

  // R1: a capture only happens under a valid mode code
  assert_capture_mode_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchRd || strobes.latchWr) |-> (modeCode[2:1] == 2'b11));

  // R3: commit follows a high write strobe seen through the two-stage synchronizer
  assert_commit_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitWr |-> $past(wrN, 2));

  // R7: drive only while a low read strobe is seen through the synchronizer
  assert_oe_read_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !$past(rdN, 2));

  // R6: upper-part split read leaves the high lanes at zero
  assert_upper_lanes_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && latSplit && latUpper) |-> (busOut[DATA_W-1:HI_W] == '0));

  // R9: no capture when both strobes were low together
  assert_no_capture_both_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchRd || strobes.latchWr) |-> !(!$past(rdN, 2) && !$past(wrN, 2)));

  // R2: at most one control event per clock
  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.latchRd, strobes.latchWr, strobes.commitWr}));
endmodule

bind split_ram_port split_ram_port_chk #(.DATA_W(DATA_W), .LO_W(LO_W)) uChk (
  .clk(clk), .rstN(rstN), .modeCode(modeCode), .rdN(rdN), .wrN(wrN),
  .busOut(busOut), .busOe(busOe), .strobes(strobes),
  .latSplit(latSplit), .latUpper(latUpper)
);

// File: tb/sim_split_ram_port.sv
module sim_split_ram_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeCode = 3'b110;
  logic [9:0]  addrIn = '0;
  logic        upperSel = 1'b0;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [23:0] busIn = '0;
  logic [23:0] busOut;
  logic        busOe;

  int checks = 0;
  int failures = 0;
  int rdHigh = 0;
  bit done = 0;
  logic [23:0] refMem [int];

  always #5 clk = ~clk;

  split_ram_port u0 (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .addrIn(addrIn), .upperSel(upperSel),
    .rdN(rdN), .wrN(wrN), .busIn(busIn), .busOut(busOut), .busOe(busOe)
  );

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock monitor: R7 idle bus
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rdN) rdHigh++; else rdHigh = 0;
      if (rdHigh >= 4) chk("R7 oe idle", {23'd0, busOe}, 24'd0);
      if (!busOe) chk("R7 undriven zero", busOut, 24'd0);
    end
  end

  function automatic logic [23:0] expRead(logic [2:0] m, int a, logic u);
    logic [23:0] w = refMem[a];
    if (!m[0]) return w;
    if (u) return {16'd0, w[23:16]};
    return {8'd0, w[15:0]};
  endfunction

  task automatic doWrite(logic [2:0] m, int a, logic u, logic [23:0] d);
    @(negedge clk);
    modeCode = m; addrIn = a[9:0]; upperSel = u; busIn = ~d; wrN = 1'b0;
    repeat (5) @(negedge clk);
    addrIn = ~a[9:0]; upperSel = ~u; busIn = d;  // R2 / R3: late changes
    repeat (2) @(negedge clk);
    wrN = 1'b1;
    repeat (5) @(negedge clk);
    busIn = d ^ 24'h5A5A5A;
    if (m[2:1] == 2'b11) begin
      if (!m[0])  refMem[a] = d;
      else if (u) refMem[a][23:16] = d[7:0];
      else        refMem[a][15:0] = d[15:0];
    end
  endtask

  task automatic doRead(logic [2:0] m, int a, logic u, string req);
    @(negedge clk);
    modeCode = m; addrIn = a[9:0]; upperSel = u; rdN = 1'b0;
    repeat (5) @(negedge clk);
    addrIn = ~a[9:0]; upperSel = ~u;
    repeat (2) @(negedge clk);
    if (m[2:1] == 2'b11) begin
      chk({req, " oe"}, {23'd0, busOe}, 24'd1);
      chk({req, " data"}, busOut, expRead(m, a, u));
    end else begin
      chk({req, " oe"}, {23'd0, busOe}, 24'd0);
      chk({req, " data"}, busOut, 24'd0);
    end
    rdN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset oe", {23'd0, busOe}, 24'd0);
    chk("R8 reset data", busOut, 24'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 after reset oe", {23'd0, busOe}, 24'd0);

    // R4 full mode, upperSel ignored
    doWrite(3'b110, 5, 1'b1, 24'h123456);
    doWrite(3'b110, 6, 1'b0, 24'hABCDEF);
    doWrite(3'b110, 0, 1'b1, 24'h0F0F0F);
    doWrite(3'b110, 1023, 1'b0, 24'hFEDCBA);
    doRead(3'b110, 5, 1'b1, "R4 full read usel1");
    doRead(3'b110, 6, 1'b0, "R4 full read usel0");
    doRead(3'b110, 1023, 1'b1, "R4 full read top addr");

    // R5 split lower part
    doWrite(3'b111, 5, 1'b0, 24'hFF9876);
    doRead(3'b111, 5, 1'b0, "R5 lower read");
    doRead(3'b110, 5, 1'b0, "R5 upper kept");

    // R6 split upper part
    doWrite(3'b111, 6, 1'b1, 24'hFFFF3C);
    doRead(3'b111, 6, 1'b1, "R6 upper read");
    doRead(3'b111, 6, 1'b0, "R6 lower kept");
    doRead(3'b110, 6, 1'b0, "R6 full after merge");

    // R1 invalid mode codes
    doWrite(3'b000, 0, 1'b0, 24'h777777);
    doRead(3'b110, 0, 1'b0, "R1 write ignored");
    doRead(3'b010, 0, 1'b0, "R1 read ignored");

    // R9 both strobes low together
    @(negedge clk);
    modeCode = 3'b110; addrIn = 10'd1023; busIn = 24'h111111; rdN = 1'b0; wrN = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 no drive", {23'd0, busOe}, 24'd0);
    rdN = 1'b1; wrN = 1'b1;
    repeat (6) @(negedge clk);
    doRead(3'b110, 1023, 1'b0, "R9 no write");

    // R2 / R3 back-to-back patterns
    for (int i = 0; i < 4; i++) begin
      doWrite(3'b110, 100 + i, 1'b0, 24'h010203 * (i + 1));
    end
    for (int i = 0; i < 4; i++) begin
      doRead(3'b110, 100 + i, 1'b0, "R2 R3 capture");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule